// File: doc/BRIEF.md
# Idle-Gap Completion Interrupt Timer

This block moderates completion interrupts for a network controller with four receive queues and one transmit queue. Each queue has its own channel that watches a one-cycle completion pulse. A completion loads a countdown, and a later completion reloads it. The channel raises its interrupt only when the countdown runs out, which means only after the queue has been silent for the programmed number of time-base ticks. A burst of traffic therefore produces one interrupt, and it comes after the burst ends.

The countdown advances on a shared tick. The tick is produced by dividing the clock by a parameter. Each channel also has a throttle value, which sets the minimum spacing between two of its interrupts. An expiry that falls inside that spacing is held until the spacing has run out, and it fires then.

The interrupt is a level. It stays high until a write-one-to-clear acknowledge on that channel's bit. Configuration arrives as 32-bit word writes. A status word gives the live count of every receive queue.

Top module: `cmpl_defer_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, every interrupt is low and `rx_status` is zero.
- R2: A completion pulse on a queue loads that queue's count with its programmed timeout. The count is visible in the next cycle.
- R3: A running count decreases by one on each tick, where a tick is every PRESCALE-th clock counted from reset. When a tick takes the count from 1 to 0, the interrupt rises in the next cycle.
- R4: A completion that arrives while a countdown is running reloads the count to the full timeout, and no interrupt results from the earlier countdown.
- R5: A programmed timeout of 0 behaves as a timeout of 1.
- R6: Configuration word 0 serves receive queues 0 and 1, and word 1 serves queues 2 and 3; in general, queue q uses word q/2. An even queue takes its timeout from bits 7:0 and its throttle from bits 15:8. An odd queue takes its timeout from bits 23:16 and its throttle from bits 31:24. Word 2 is the transmit channel, with its timeout in bits 7:0 and its throttle in bits 15:8. Word 3 is ignored. After reset every timeout is 1 and every throttle is 0.
- R7: `rx_status` byte k, which is bits 8k+7:8k, shows the live count of receive queue k.
- R8: After a channel fires, the channel loads a hold window equal to its throttle value, and the window drops by one per tick. An expiry that occurs while the window is nonzero is kept pending and fires in the cycle after the window reaches zero.
- R9: An interrupt stays high until its own acknowledge bit is pulsed. An acknowledge clears only that channel. A firing in the same cycle as an acknowledge wins.
- R10: After expiry, a channel's count stays at zero and the channel does not fire again until a new completion arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | ADDR_W | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cmpl_rx | input | NUM_RX | Receive completion pulses, one per queue |
| cmpl_tx | input | 1 | Transmit completion pulse |
| ack_rx | input | NUM_RX | Write-one-to-clear acknowledge, receive channels |
| ack_tx | input | 1 | Write-one-to-clear acknowledge, transmit channel |
| irq_rx | output | NUM_RX | Receive channel interrupt levels |
| irq_tx | output | 1 | Transmit channel interrupt level |
| rx_status | output | 8*NUM_RX | Live receive counts, one byte per queue |

## Verification
A wrong count, a wrong load value, or a mis-decoded configuration field shows in the affected `rx_status` byte on the cycle after the completion or tick that caused it. The bench compares every byte on every clock, so such a fault is caught within one cycle. A wrong running or pending flag, or a wrong hold window, can only be seen through the interrupt level. It appears as an interrupt that is early, late, repeated or missing, at most one throttle window after the point where the cycle-accurate model predicts it. The transmit channel has no count output, so its faults are caught through `irq_tx` alone.

// File: rtl/gap_pkg.sv
package gap_pkg;

    localparam int unsigned VAL_W  = 8;
    localparam int unsigned WORD_W = 32;

    typedef logic [VAL_W-1:0] val_t;

    // Per-channel programmed settings
    typedef struct packed {
        val_t timeout;
        val_t throttle;
    } chan_cfg_t;

    // Per-channel live state
    typedef struct packed {
        val_t cnt;    // idle countdown
        logic run;    // countdown active
        logic pend;   // expiry waiting for the hold window
        val_t hold;   // ticks left before another firing is allowed
        logic irq;    // interrupt level
    } chan_state_t;

    // R5: a zero timeout is promoted to one
    function automatic val_t eff_timeout(input val_t t);
        return (t == '0) ? val_t'(1) : t;
    endfunction

endpackage

// File: rtl/gap_tick_gen.sv
module gap_tick_gen #(
    parameter int unsigned PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int unsigned CW   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int unsigned LAST = (PRESCALE > 1) ? PRESCALE - 1 : 0;

    typedef struct packed {
        logic [CW-1:0] div;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.div == CW'(LAST));
        if (tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gap_cfg_regs.sv
module gap_cfg_regs
    import gap_pkg::*;
#(
    parameter int unsigned NUM_RX = 4,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [WORD_W-1:0]       wdata,
    output chan_cfg_t [NUM_RX:0]    cfg
);

    localparam int unsigned NUM_CH  = NUM_RX + 1;
    localparam int unsigned TX_WORD = (NUM_RX + 1) / 2;
    localparam chan_cfg_t   CFG_RST = '{timeout: val_t'(1), throttle: '0};

    typedef struct packed {
        chan_cfg_t [NUM_RX:0] ch;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    // Half-word slices of the write data
    chan_cfg_t lo_half, hi_half;

    always_comb begin
        // R6: even queue / tx in the low half, odd queue in the high half
        lo_half = '{timeout: wdata[7:0],   throttle: wdata[15:8]};
        hi_half = '{timeout: wdata[23:16], throttle: wdata[31:24]};
        st_d = st_q;
        if (we) begin
            for (int q = 0; q < int'(NUM_RX); q++) begin
                if (addr == ADDR_W'(q / 2)) begin
                    st_d.ch[q] = (q % 2 == 0) ? lo_half : hi_half;
                end
            end
            if (addr == ADDR_W'(TX_WORD)) begin
                st_d.ch[NUM_RX] = lo_half;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ch <= {NUM_CH{CFG_RST}};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.ch;

endmodule

// File: rtl/gap_channel.sv
module gap_channel
    import gap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      cmpl,
    input  logic      ack,
    input  chan_cfg_t cfg,
    output logic      irq,
    output val_t      count
);

    chan_state_t st_d, st_q;
    logic        expire;
    logic        fire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;

        // Countdown: a completion always wins over a tick (R2, R4)
        if (cmpl) begin
            st_d.cnt = eff_timeout(cfg.timeout);
            st_d.run = 1'b1;
        end else if (tick && st_q.run) begin
            if (st_q.cnt <= val_t'(1)) begin
                st_d.cnt = '0;
                st_d.run = 1'b0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        // Hold window shrinks once per tick (R8)
        if (tick && (st_q.hold != '0)) begin
            st_d.hold = st_q.hold - 1'b1;
        end

        // Fire now, or park the expiry until the window is closed
        fire = (expire || st_q.pend) && (st_q.hold == '0);
        if (fire) begin
            st_d.irq  = 1'b1;
            st_d.hold = cfg.throttle;
            st_d.pend = 1'b0;
        end else begin
            if (expire) begin
                st_d.pend = 1'b1;
            end
            if (ack) begin
                st_d.irq = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq   = st_q.irq;
    assign count = st_q.cnt;

endmodule

// File: rtl/cmpl_defer_timer.sv
module cmpl_defer_timer
    import gap_pkg::*;
#(
    parameter int unsigned NUM_RX   = 4,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned PRESCALE = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wdata,
    input  logic [NUM_RX-1:0]       cmpl_rx,
    input  logic                    cmpl_tx,
    input  logic [NUM_RX-1:0]       ack_rx,
    input  logic                    ack_tx,
    output logic [NUM_RX-1:0]       irq_rx,
    output logic                    irq_tx,
    output logic [8*NUM_RX-1:0]     rx_status
);

    localparam int unsigned NUM_CH = NUM_RX + 1;

    logic                  tick;
    chan_cfg_t [NUM_RX:0]  cfg;
    logic [NUM_CH-1:0]     cmpl_all;
    logic [NUM_CH-1:0]     ack_all;
    logic [NUM_CH-1:0]     irq_all;
    val_t                  tx_cnt_unused;

    assign cmpl_all = {cmpl_tx, cmpl_rx};
    assign ack_all  = {ack_tx, ack_rx};

    gap_tick_gen #(
        .PRESCALE (PRESCALE)
    ) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    gap_cfg_regs #(
        .NUM_RX (NUM_RX),
        .ADDR_W (ADDR_W)
    ) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
        val_t ch_count;

        gap_channel i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .cmpl  (cmpl_all[c]),
            .ack   (ack_all[c]),
            .cfg   (cfg[c]),
            .irq   (irq_all[c]),
            .count (ch_count)
        );

        if (c < int'(NUM_RX)) begin : g_rx_status
            // R7: byte c of the status word
            assign rx_status[8*c +: 8] = ch_count;
        end else begin : g_tx_count
            assign tx_cnt_unused = ch_count;
        end
    end

    assign irq_rx = irq_all[NUM_RX-1:0];
    assign irq_tx = irq_all[NUM_RX];

endmodule

// File: rtl/gap_checker.sv
module gap_checker #(
    parameter int unsigned NUM_RX = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_RX-1:0]   cmpl_rx,
    input logic [NUM_RX-1:0]   ack_rx,
    input logic                ack_tx,
    input logic [NUM_RX-1:0]   irq_rx,
    input logic                irq_tx,
    input logic [8*NUM_RX-1:0] rx_status
);

    for (genvar q = 0; q < int'(NUM_RX); q++) begin : g_q
        // R2 with R5: a load never leaves a zero count
        assert_load_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cmpl_rx[q] |=> (rx_status[8*q +: 8] != 8'd0));

        // R4: the count only grows on a completion
        assert_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !cmpl_rx[q] |=> (rx_status[8*q +: 8] <= $past(rx_status[8*q +: 8])));

        // R10: an idle, expired channel stays at zero
        assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_status[8*q +: 8] == 8'd0 && !cmpl_rx[q]) |=> (rx_status[8*q +: 8] == 8'd0));

        // R9: level held until acknowledged
        assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_rx[q] && !ack_rx[q]) |=> irq_rx[q]);
    end

    // R9: same for the transmit channel
    assert_tx_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && !ack_tx) |=> irq_tx);

endmodule

bind cmpl_defer_timer gap_checker #(
    .NUM_RX (NUM_RX)
) i_gap_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmpl_rx   (cmpl_rx),
    .ack_rx    (ack_rx),
    .ack_tx    (ack_tx),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx),
    .rx_status (rx_status)
);

// File: tb/test_cmpl_defer_timer.sv
`timescale 1ns/1ps
module test_cmpl_defer_timer;

    localparam int PRE = 4;
    localparam int NRX = 4;
    localparam int NCH = NRX + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cmpl_rx = '0;
    logic        cmpl_tx = 1'b0;
    logic [3:0]  ack_rx = '0;
    logic        ack_tx = 1'b0;
    logic [3:0]  irq_rx;
    logic        irq_tx;
    logic [31:0] rx_status;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    cmpl_defer_timer #(
        .NUM_RX   (NRX),
        .ADDR_W   (2),
        .PRESCALE (PRE)
    ) i_cmpl_defer_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cmpl_rx   (cmpl_rx),
        .cmpl_tx   (cmpl_tx),
        .ack_rx    (ack_rx),
        .ack_tx    (ack_tx),
        .irq_rx    (irq_rx),
        .irq_tx    (irq_tx),
        .rx_status (rx_status)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_pre;
    int m_cnt[NCH], m_run[NCH], m_pend[NCH], m_hold[NCH], m_irq[NCH];
    int m_to[NCH], m_thr[NCH];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0;
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = 0; m_run[c] = 0; m_pend[c] = 0; m_hold[c] = 0; m_irq[c] = 0;
                m_to[c] = 1; m_thr[c] = 0;
            end
        end else begin
            bit tk;
            tk = (m_pre == PRE - 1);
            m_pre = tk ? 0 : m_pre + 1;
            for (int c = 0; c < NCH; c++) begin
                bit cm, ak, ex, fr;
                int nh;
                cm = (c < NRX) ? cmpl_rx[c] : cmpl_tx;
                ak = (c < NRX) ? ack_rx[c] : ack_tx;
                ex = 0;
                nh = m_hold[c];
                if (tk && nh > 0) nh = nh - 1;
                if (cm) begin
                    m_cnt[c] = (m_to[c] == 0) ? 1 : m_to[c];
                    m_run[c] = 1;
                end else if (tk && m_run[c] != 0) begin
                    if (m_cnt[c] == 1) begin
                        m_cnt[c] = 0; m_run[c] = 0; ex = 1;
                    end else begin
                        m_cnt[c] = m_cnt[c] - 1;
                    end
                end
                fr = (ex || m_pend[c] != 0) && m_hold[c] == 0;
                if (fr) begin
                    m_irq[c] = 1; nh = m_thr[c]; m_pend[c] = 0;
                end else begin
                    if (ex) m_pend[c] = 1;
                    if (ak) m_irq[c] = 0;
                end
                m_hold[c] = nh;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: begin
                        m_to[0] = cfg_wdata[7:0];   m_thr[0] = cfg_wdata[15:8];
                        m_to[1] = cfg_wdata[23:16]; m_thr[1] = cfg_wdata[31:24];
                    end
                    2'd1: begin
                        m_to[2] = cfg_wdata[7:0];   m_thr[2] = cfg_wdata[15:8];
                        m_to[3] = cfg_wdata[23:16]; m_thr[3] = cfg_wdata[31:24];
                    end
                    2'd2: begin
                        m_to[4] = cfg_wdata[7:0];   m_thr[4] = cfg_wdata[15:8];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        logic [31:0] es;
        logic [4:0]  ei;
        for (int q = 0; q < NRX; q++) es[8*q +: 8] = 8'(m_cnt[q]);
        for (int c = 0; c < NCH; c++) ei[c] = (m_irq[c] != 0);
        check("R3/R7 rx_status vs model", rx_status, es);
        check("R8/R9 irq vs model", {irq_tx, irq_rx}, ei);
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] rx, input logic tx);
        @(negedge clk);
        cmpl_rx = rx; cmpl_tx = tx;
        @(negedge clk);
        cmpl_rx = '0; cmpl_tx = 1'b0;
    endtask

    task automatic ack(input logic [3:0] rx, input logic tx);
        @(negedge clk);
        ack_rx = rx; ack_tx = tx;
        @(negedge clk);
        ack_rx = '0; ack_tx = 1'b0;
    endtask

    initial begin
        // R1: reset state
        idle(3);
        check("R1 irq in reset", {irq_tx, irq_rx}, 5'd0);
        check("R1 status in reset", rx_status, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {irq_tx, irq_rx}, 5'd0);
        check("R1 status after reset", rx_status, 32'd0);

        // R6, R7, R2: queue 0 timeout 5 (low half), queue 1 timeout 9 (high half)
        cfg_write(2'd0, 32'h0009_0005);
        pulse(4'b0011, 1'b0);
        check("R6 R7 R2 byte0 load", rx_status[7:0], 8'd5);
        check("R6 R7 R2 byte1 load", rx_status[15:8], 8'd9);

        // R3: both expire and raise their interrupts
        idle(48);
        check("R3 q0 fired", irq_rx[0], 1'b1);
        check("R3 q1 fired", irq_rx[1], 1'b1);
        idle(60);
        check("R9 q0 level held", irq_rx[0], 1'b1);
        check("R10 q0 stays idle", rx_status[7:0], 8'd0);
        ack(4'b0001, 1'b0);
        check("R9 q0 cleared by ack", irq_rx[0], 1'b0);
        check("R9 q1 untouched by q0 ack", irq_rx[1], 1'b1);
        idle(40);
        check("R10 no re-fire without completion", irq_rx[0], 1'b0);
        ack(4'b0010, 1'b0);

        // R5: queue 2 timeout 0, queue 3 timeout 12
        cfg_write(2'd1, 32'h000C_0000);
        pulse(4'b0100, 1'b0);
        check("R5 zero timeout loads one", rx_status[23:16], 8'd1);

        // R4: reload during countdown
        pulse(4'b1000, 1'b0);
        check("R4 first load", rx_status[31:24], 8'd12);
        idle(20);
        pulse(4'b1000, 1'b0);
        check("R4 reload to full value", rx_status[31:24], 8'd12);
        check("R4 no irq from earlier countdown", irq_rx[3], 1'b0);
        idle(60);
        ack(4'b1100, 1'b0);

        // R8: tx throttle 20 ticks, timeout 1
        cfg_write(2'd2, 32'h0000_1401);
        pulse(4'b0000, 1'b1);
        idle(12);
        check("R3 tx fired", irq_tx, 1'b1);
        ack(4'b0000, 1'b1);
        pulse(4'b0000, 1'b1);
        idle(12);
        check("R8 expiry held inside window", irq_tx, 1'b0);
        idle(100);
        check("R8 pending fires after window", irq_tx, 1'b1);
        ack(4'b0000, 1'b1);

        // R6: unmapped word is ignored (queue 0 still loads 5)
        cfg_write(2'd3, 32'h0707_0707);
        pulse(4'b0001, 1'b0);
        check("R6 word 3 ignored", rx_status[7:0], 8'd5);

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            for (int q = 0; q < NRX; q++) begin
                cmpl_rx[q] = ($urandom % 32) == 0;
                ack_rx[q]  = ($urandom % 16) == 0;
            end
            cmpl_tx = ($urandom % 32) == 0;
            ack_tx  = ($urandom % 16) == 0;
            cfg_we  = ($urandom % 64) == 0;
            cfg_addr  = 2'($urandom % 4);
            cfg_wdata = $urandom & 32'h0F0F_0F0F;
        end
        @(negedge clk);
        cmpl_rx = '0; cmpl_tx = 1'b0; ack_rx = '0; ack_tx = 1'b0; cfg_we = 1'b0;
        idle(5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule